// File: doc/BRIEF.md
# Synchronous burst SRAM controller

This block is the clocked front end of a flow-through synchronous burst memory with a small on-chip array. Every rising clock edge it samples the address, three chip enables, two address strobes, a burst advance input and the write controls. From these it decides whether the cycle starts a new burst, continues one, suspends one or deselects the device. A 2-bit burst counter steps through four word addresses in either linear or XOR-interleaved order. The upper address bits stay fixed for the whole burst.

Writes go into an array of words split into byte lanes, each lane nine bits wide. Read data is taken from the registered address without a further register, so it is valid in the same cycle that follows the command edge. The data bus is a split input, output and drive-enable triple that feeds a pad tri-state buffer. The active-low output enable gates the drive enable with no clock in between.

Top module: `sbsr_ctrl`

## Requirements
- R1: While reset is high and after it falls, the block is deselected with the data bus released and the burst offset cleared. Cycles with no valid address strobe leave it deselected.
- R2: With `order_il` low, the word address low bits of a burst are start+0, +1, +2, +3 modulo 4. The read data of each address is on `dq_o` in the cycle after the edge that selected it.
- R3: With `order_il` high, the low bits are start XOR 0, 1, 2, 3 in turn.
- R4: The fifth address of an uninterrupted burst equals the starting address.
- R5: In a cycle with no strobe and `adv_n` high, the burst address is held.
- R6: A strobe cycle selects the device only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Otherwise it deselects the device and releases the bus. `ce2` and `ce3_n` are ignored in cycles without a strobe.
- R7: A cycle started by `adsp_n` low with `ce1_n` low is a read whatever the write inputs are. It modifies no memory.
- R8: A cycle started by `adsc_n` low is a write when `gw_n` or `bw_n` is low and a read otherwise. Continue cycles write at the stepped address.
- R9: `gw_n` low writes all lanes. Otherwise `bw_n` low writes lane l (bits 9l+8 down to 9l of `dq_i`) only where `lane_n[l]` is low. Unselected lanes keep their contents.
- R10: The bus is not driven in the cycle after any write command, including a write with no lanes selected.
- R11: Raising `oe_n` releases the bus without waiting for a clock edge. Read cycles with `oe_n` high still step the burst counter.
- R12: Address bits above the two lowest do not change from one burst step to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | External word address |
| ce1_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high, sampled with a strobe |
| ce3_n | input | 1 | Secondary chip enable, active low, sampled with a strobe |
| adsp_n | input | 1 | Read-only address strobe, active low, gated by `ce1_n` |
| adsc_n | input | 1 | General address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, all lanes, active low |
| bw_n | input | 1 | Byte-write gate, active low |
| lane_n | input | LANES | Per-lane write selects, active low |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | DW | Write data from the pad |
| dq_o | output | DW | Read data to the pad |
| dq_en | output | 1 | Pad driver enable, high drives `dq_o` |

## Verification
Each command is applied before a clock edge, and its result is due in the cycle after that edge. The burst address, the read data and the drive enable all change on that edge, so every check samples one time unit after it and before the next inputs change. The effect of `oe_n` needs no edge and is checked one time unit after the input moves. Write results are checked by reading the address back in a later command, which also shows which lanes kept their old contents.

// File: rtl/sbsr_pkg.sv
package sbsr_pkg;

  // How the burst address moves on the coming edge
  typedef enum logic [1:0] {
    AOP_KEEP = 2'd0,
    AOP_LOAD = 2'd1,
    AOP_STEP = 2'd2
  } aop_e;

  // Low word-address bits for a given offset into the burst
  function automatic logic [1:0] seq_lsb(input logic [1:0] base,
                                         input logic [1:0] ofs,
                                         input logic       il);
    logic [1:0] r;
    if (il) r = base ^ ofs;
    else    r = base + ofs;
    return r;
  endfunction

endpackage

// File: rtl/sbsr_lane_decode.sv
module sbsr_lane_decode #(
  parameter int LANES = 4
) (
  input  logic             gw_n,
  input  logic             bw_n,
  input  logic [LANES-1:0] lane_n,
  output logic             wr_req,
  output logic [LANES-1:0] lane_we
);

  // Any write control low makes the cycle a write, even with no lane chosen
  assign wr_req = ~gw_n | ~bw_n;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_we[l] = ~gw_n | (~bw_n & ~lane_n[l]);
    end
  endgenerate

endmodule

// File: rtl/sbsr_cycle_decode.sv
module sbsr_cycle_decode
  import sbsr_pkg::*;
(
  input  logic adsp_n,
  input  logic adsc_n,
  input  logic adv_n,
  input  logic ce1_n,
  input  logic ce2,
  input  logic ce3_n,
  input  logic wr_req,
  input  logic active_q,
  output aop_e aop,
  output logic nxt_active,
  output logic nxt_write
);

  logic en_ok;
  logic p_hit;

  assign en_ok = ~ce1_n & ce2 & ~ce3_n;
  // The read-only strobe only counts while the primary enable is low
  assign p_hit = ~adsp_n & ~ce1_n;

  always_comb begin
    aop        = AOP_KEEP;
    nxt_active = active_q;
    nxt_write  = 1'b0;
    if (p_hit) begin
      if (en_ok) begin
        aop        = AOP_LOAD;
        nxt_active = 1'b1;
      end else begin
        nxt_active = 1'b0;
      end
    end else if (!adsc_n) begin
      if (en_ok) begin
        aop        = AOP_LOAD;
        nxt_active = 1'b1;
        nxt_write  = wr_req;
      end else begin
        nxt_active = 1'b0;
      end
    end else if (active_q) begin
      aop       = adv_n ? AOP_KEEP : AOP_STEP;
      nxt_write = wr_req;
    end
  end

endmodule

// File: rtl/sbsr_burst_addr.sv
module sbsr_burst_addr
  import sbsr_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  aop_e          aop,
  input  logic          il,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] addr_now,
  output logic [AW-1:0] addr_q
);

  localparam int UW = AW - 2;

  logic [UW-1:0] upper_q;
  logic [1:0]    base_q;
  logic [1:0]    ofs_q;
  logic [1:0]    ofs_inc;

  assign ofs_inc = ofs_q + 2'd1;
  assign addr_q  = {upper_q, seq_lsb(base_q, ofs_q, il)};

  // Address used by a write taking place at the coming edge
  always_comb begin
    case (aop)
      AOP_LOAD: addr_now = ext_addr;
      AOP_STEP: addr_now = {upper_q, seq_lsb(base_q, ofs_inc, il)};
      default:  addr_now = addr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      base_q  <= '0;
      ofs_q   <= '0;
    end else begin
      case (aop)
        AOP_LOAD: begin
          upper_q <= ext_addr[AW-1:2];
          base_q  <= ext_addr[1:0];
          ofs_q   <= '0;
        end
        AOP_STEP: ofs_q <= ofs_inc;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sbsr_store.sv
module sbsr_store #(
  parameter int DEPTH  = 1024,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int AW     = $clog2(DEPTH),
  parameter int DW     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic [LANES-1:0] we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Per-lane write enables on one array
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we[l]) mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
    end
  end

  // Flow-through read from the registered address
  assign rdata = mem[raddr];

endmodule

// File: rtl/sbsr_ctrl.sv
module sbsr_ctrl
  import sbsr_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bw_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             order_il,
  input  logic             oe_n,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    dq_o,
  output logic             dq_en
);

  aop_e             aop;
  logic             wr_req;
  logic [LANES-1:0] lane_we;
  logic             nxt_active;
  logic             nxt_write;
  logic             active_q;
  logic             rd_q;
  logic [AW-1:0]    addr_now;
  logic [AW-1:0]    cur_addr;
  logic [LANES-1:0] mem_we;

  sbsr_lane_decode #(.LANES(LANES)) u_lanes (
    .gw_n    (gw_n),
    .bw_n    (bw_n),
    .lane_n  (lane_n),
    .wr_req  (wr_req),
    .lane_we (lane_we)
  );

  sbsr_cycle_decode u_cycle (
    .adsp_n     (adsp_n),
    .adsc_n     (adsc_n),
    .adv_n      (adv_n),
    .ce1_n      (ce1_n),
    .ce2        (ce2),
    .ce3_n      (ce3_n),
    .wr_req     (wr_req),
    .active_q   (active_q),
    .aop        (aop),
    .nxt_active (nxt_active),
    .nxt_write  (nxt_write)
  );

  sbsr_burst_addr #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .aop      (aop),
    .il       (order_il),
    .ext_addr (addr),
    .addr_now (addr_now),
    .addr_q   (cur_addr)
  );

  assign mem_we = lane_we & {LANES{nxt_active & nxt_write}};

  sbsr_store #(
    .DEPTH  (DEPTH),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (addr_now),
    .wdata (dq_i),
    .raddr (cur_addr),
    .rdata (dq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      active_q <= nxt_active;
      rd_q     <= nxt_active & ~nxt_write;
    end
  end

  // Output enable acts without a clock edge
  assign dq_en = active_q & rd_q & ~oe_n;

endmodule

// File: rtl/sbsr_ctrl_chk.sv
module sbsr_ctrl_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          ce1_n,
  input logic          ce2,
  input logic          ce3_n,
  input logic          adsp_n,
  input logic          adsc_n,
  input logic          adv_n,
  input logic          gw_n,
  input logic          bw_n,
  input logic          order_il,
  input logic          oe_n,
  input logic          dq_en,
  input logic          active_q,
  input logic [AW-1:0] cur_addr
);

  logic en_ok, strobe, quiet;
  assign en_ok  = ~ce1_n & ce2 & ~ce3_n;
  assign strobe = (~adsp_n & ~ce1_n) | ~adsc_n;
  assign quiet  = ~strobe;

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!dq_en && cur_addr == '0));

  p_linear_step_r2: assert property (@(posedge clk) disable iff (rst)
    (active_q && quiet && !adv_n && !order_il) |=>
      (order_il || cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

  p_suspend_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (active_q && quiet && adv_n) |=> ($stable(cur_addr) || !$stable(order_il)));

  p_deselect_release_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe && !en_ok) |=> !dq_en);

  p_adsp_reads_r7: assert property (@(posedge clk) disable iff (rst)
    (!adsp_n && en_ok) |=> (dq_en || oe_n));

  p_write_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    ((adsp_n || ce1_n) && !adsc_n && en_ok && (!gw_n || !bw_n)) |=> !dq_en);

  p_upper_hold_r12: assert property (@(posedge clk) disable iff (rst)
    quiet |=> $stable(cur_addr[AW-1:2]));

endmodule

bind sbsr_ctrl sbsr_ctrl_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ce1_n    (ce1_n),
  .ce2      (ce2),
  .ce3_n    (ce3_n),
  .adsp_n   (adsp_n),
  .adsc_n   (adsc_n),
  .adv_n    (adv_n),
  .gw_n     (gw_n),
  .bw_n     (bw_n),
  .order_il (order_il),
  .oe_n     (oe_n),
  .dq_en    (dq_en),
  .active_q (active_q),
  .cur_addr (cur_addr)
);

// File: tb/test_sbsr_ctrl.sv
module test_sbsr_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 1024;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int AW     = 10;
  localparam int DW     = 36;

  // {order, start[1:0], five expected low address bits}
  localparam logic [12:0] VEC [8] = '{
    13'b0_00_00_01_10_11_00,
    13'b0_01_01_10_11_00_01,
    13'b0_10_10_11_00_01_10,
    13'b0_11_11_00_01_10_11,
    13'b1_00_00_01_10_11_00,
    13'b1_01_01_00_11_10_01,
    13'b1_10_10_11_00_01_10,
    13'b1_11_11_10_01_00_11
  };

  logic clk = 1'b0;
  logic rst;
  logic [AW-1:0] addr;
  logic ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bw_n, order_il, oe_n;
  logic [LANES-1:0] lane_n;
  logic [DW-1:0] dq_i, dq_o;
  logic dq_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbsr_ctrl #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) i_sbsr_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bw_n(bw_n),
    .lane_n(lane_n), .order_il(order_il), .oe_n(oe_n), .dq_i(dq_i),
    .dq_o(dq_o), .dq_en(dq_en)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {~a[8:0], a[8:0] ^ 9'h155, a[9], a[7:0], a[8:0]};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bw_n = 1'b1; lane_n = '1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
  endtask

  task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic g, input logic b, input logic [LANES-1:0] ln);
    idle();
    addr = a; adsc_n = 1'b0; dq_i = d; gw_n = g; bw_n = b; lane_n = ln;
    tick();
    idle();
  endtask

  task automatic rd_start(input logic [AW-1:0] a);
    idle();
    addr = a; adsc_n = 1'b0;
    tick();
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] old_w, new_w, exp_w;
    logic [AW-1:0] a_t;
    rst = 1'b1; idle(); addr = '0; dq_i = '0; order_il = 1'b0; oe_n = 1'b0;
    repeat (3) tick();
    chk("R1 bus in reset", {35'd0, dq_en}, 36'd0);
    rst = 1'b0;
    tick();
    chk("R1 bus after reset", {35'd0, dq_en}, 36'd0);
    adv_n = 1'b0;
    tick();
    chk("R1 continue ignored while deselected", {35'd0, dq_en}, 36'd0);
    idle();

    // Preload eight groups of four words
    for (int g = 0; g < 8; g++) begin
      for (int w = 0; w < 4; w++) begin
        a_t = {8'h10 + 8'(g), 2'(w)};
        wr_word(a_t, pat(a_t), 1'b0, 1'b1, '1);
      end
    end

    // Burst order table: R2 linear, R3 interleaved, R4 wrap, R12 upper fixed
    for (int i = 0; i < 8; i++) begin
      logic [12:0] e;
      logic [7:0] up;
      e = VEC[i];
      up = 8'h10 + 8'(i);
      order_il = e[12];
      rd_start({up, e[11:10]});
      adv_n = 1'b0;
      chk(e[12] ? "R3 R12 first" : "R2 R12 first", dq_o, pat({up, e[9:8]}));
      for (int k = 1; k < 5; k++) begin
        tick();
        chk(k == 4 ? "R4 wrap" : (e[12] ? "R3 R12 step" : "R2 R12 step"),
            dq_o, pat({up, e[9-2*k -: 2]}));
      end
      idle();
    end
    order_il = 1'b0;

    // R8 / R9: full write, read, then lane write
    a_t = 10'h3F0;
    old_w = 36'h1_2345_6789;
    wr_word(a_t, old_w, 1'b0, 1'b1, '1);
    rd_start(a_t);
    chk("R8 read after adsc write", dq_o, old_w);
    chk("R8 read drives bus", {35'd0, dq_en}, 36'd1);
    new_w = 36'hF_EDCB_A987;
    wr_word(a_t, new_w, 1'b1, 1'b0, 4'b1010);
    for (int l = 0; l < LANES; l++)
      exp_w[l*LANE_W +: LANE_W] = (l == 0 || l == 2) ? new_w[l*LANE_W +: LANE_W]
                                                      : old_w[l*LANE_W +: LANE_W];
    rd_start(a_t);
    chk("R9 lanes 0 and 2 only", dq_o, exp_w);

    // R10: write with no lane keeps bus quiet and memory intact
    idle();
    addr = a_t; adsc_n = 1'b0; bw_n = 1'b0; lane_n = '1; dq_i = '0;
    tick();
    chk("R10 no-lane write bus quiet", {35'd0, dq_en}, 36'd0);
    rd_start(a_t);
    chk("R9 no-lane write leaves data", dq_o, exp_w);

    // R9: global write overrides lane selects
    wr_word(a_t, 36'hA_5A5A_5A5A, 1'b0, 1'b0, 4'b1110);
    rd_start(a_t);
    chk("R9 global write all lanes", dq_o, 36'hA_5A5A_5A5A);

    // R7: adsp start with write inputs low is a read
    idle();
    addr = a_t; adsp_n = 1'b0; gw_n = 1'b0; dq_i = 36'h0_0000_0000;
    tick();
    chk("R7 adsp drives bus", {35'd0, dq_en}, 36'd1);
    chk("R7 adsp read data", dq_o, 36'hA_5A5A_5A5A);
    rd_start(a_t);
    chk("R7 memory untouched", dq_o, 36'hA_5A5A_5A5A);

    // R6: enable decoding
    idle(); ce1_n = 1'b1; adsc_n = 1'b0;
    tick();
    chk("R6 ce1 high deselects", {35'd0, dq_en}, 36'd0);
    idle(); ce2 = 1'b0; adsc_n = 1'b0;
    tick();
    chk("R6 ce2 low deselects", {35'd0, dq_en}, 36'd0);
    idle(); ce3_n = 1'b1; adsc_n = 1'b0;
    tick();
    chk("R6 ce3 high deselects", {35'd0, dq_en}, 36'd0);
    rd_start(10'h040);
    ce2 = 1'b0; ce3_n = 1'b1;
    tick();
    chk("R6 enables ignored without strobe", {35'd0, dq_en}, 36'd1);
    chk("R6 R5 data held", dq_o, pat(10'h040));
    idle();

    // R5: suspend and advance
    rd_start(10'h040);
    tick();
    chk("R5 suspend holds", dq_o, pat(10'h040));
    adv_n = 1'b0;
    tick();
    chk("R5 step after suspend", dq_o, pat(10'h041));
    adv_n = 1'b1;
    tick();
    chk("R5 suspend again", dq_o, pat(10'h041));

    // R11: async output enable and dummy reads
    oe_n = 1'b1;
    #1;
    chk("R11 bus released at once", {35'd0, dq_en}, 36'd0);
    adv_n = 1'b0;
    tick();
    tick();
    oe_n = 1'b0; adv_n = 1'b1;
    #1;
    chk("R11 bus back", {35'd0, dq_en}, 36'd1);
    chk("R11 dummy reads advanced", dq_o, pat(10'h043));

    // R8 / R3: burst write in interleaved order
    order_il = 1'b1;
    idle();
    addr = 10'h0C2; adsc_n = 1'b0; gw_n = 1'b0; dq_i = 36'h1_1111_1111;
    tick();
    chk("R10 write start bus quiet", {35'd0, dq_en}, 36'd0);
    idle();
    adv_n = 1'b0; gw_n = 1'b0; dq_i = 36'h2_2222_2222;
    tick();
    chk("R10 continue write bus quiet", {35'd0, dq_en}, 36'd0);
    rd_start(10'h0C3);
    chk("R8 R3 continue write address", dq_o, 36'h2_2222_2222);
    rd_start(10'h0C2);
    chk("R8 start write address", dq_o, 36'h1_1111_1111);
    order_il = 1'b0;

    // R1: reset in the middle of a burst
    rst = 1'b1;
    tick();
    rst = 1'b0;
    tick();
    chk("R1 reset mid burst", {35'd0, dq_en}, 36'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule